// File: doc/BRIEF.md
# Length-framed byte-to-JTAG bridge controller

The bridge sits between a host serial receiver and a JTAG shift engine. It reads a stream of bytes. A nonzero byte opens a data frame and gives the number of payload bytes that follow. Each payload byte goes to a separate shift engine through a one-cycle start pulse and a done pulse. The bridge then returns two bytes for that payload byte: a status byte, then the byte captured from TDO.

A zero byte escapes into a one-byte special command. Special commands have several jobs:
- drive the RESET, TMS, TDI and TCK pins directly;
- sample TDO;
- pick the shift destination (IR or DR) and the shift width (3 or 8 bits);
- set the clock-pacing timer mode bit and its low and high reload values.

Each special command answers with one byte. That byte is normally an echo of the command code, and an error code when the command is unknown.

Responses leave through a valid/ready handshake. Input is held off while a shift is running and while responses are still waiting to go out. An exit command puts the bridge into an idle state, where it drops input until an external enable brings it back.

Top module: `jtag_byte_bridge`

## Requirements
- R1: After reset the bridge sets these outputs:
  - the RESET pin high; TMS, TDI and TCK low;
  - DR selected (`sh_ir_o`=0) and 8-bit width (`sh_wide_o`=1);
  - timer mode 0 and both reload values 0x00;
  - `idle_o` low, `tx_valid_o` low and `rx_ready_o` high.
- R2: A nonzero first byte N is followed by N data bytes. For each data byte the bridge raises `sh_start_o` for exactly one cycle. During that cycle `sh_data_o` carries the byte, masked to its low 3 bits when the 3-bit width is selected, and `sh_ir_o`/`sh_wide_o` carry the current selection.
- R3: For each `sh_done_i` pulse the bridge emits two bytes in this order: the status byte, then `sh_capt_i`. `rx_ready_o` stays low from the start pulse until both bytes have been taken.
- R4: A status equal to `STAT_OK` is returned zero-extended. Any other status is returned as 0xC0 OR the status bits.
- R5: A first byte of 0x00 makes the next byte a special command, answered by one byte. Codes 0x04/0x05 set/clear the RESET pin, 0x09/0x0A set/clear TMS and 0x0B/0x0C set/clear TDI, each echoing its code.
- R6: Code 0x06 drives `tck_o` high for exactly one cycle and echoes 0x06. Code 0x07 returns 0x01 when `tdo_i` is high and 0x00 when it is low.
- R7: Code 0x01 selects IR and 0x02 selects DR. Code 0x03 selects 3-bit width and 0x08 selects 8-bit width. Each of these echoes its code.
- R8: Codes 0x0D/0x0E set/clear the timer mode bit and echo. Code 0x11 (or 0x12) echoes, then loads the very next raw byte into the low (or high) reload value, with no response. That byte is taken as raw data even when it is 0x00.
- R9: Any special code other than 0x00–0x0E, 0x11 and 0x12 returns 0x80 and changes no pin or setting.
- R10: Code 0x00 echoes 0x00 and raises `idle_o`. While idle, the bridge accepts bytes and discards them, with no response and no pin change. A high level on `bin_en_i` clears idle.
- R11: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` stays high and `tx_data_o` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bin_en_i | input | 1 | Leaves the idle state when high |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Received byte valid |
| rx_ready_o | output | 1 | Bridge can take a byte |
| tx_data_o | output | 8 | Response byte |
| tx_valid_o | output | 1 | Response byte valid |
| tx_ready_i | input | 1 | Transmitter takes the response byte |
| sh_start_o | output | 1 | One-cycle start pulse to the shift engine |
| sh_data_o | output | 8 | Byte to shift |
| sh_ir_o | output | 1 | Destination: 1 = IR, 0 = DR |
| sh_wide_o | output | 1 | Width: 1 = 8 bits, 0 = 3 bits |
| sh_done_i | input | 1 | Shift finished, capture and status valid |
| sh_capt_i | input | 8 | Byte captured from TDO |
| sh_status_i | input | STAT_W | Status bits from the TAP |
| tdo_i | input | 1 | Direct TDO level |
| tck_o | output | 1 | Direct TCK pin |
| tms_o | output | 1 | Direct TMS pin |
| tdi_o | output | 1 | Direct TDI pin |
| rst_pin_o | output | 1 | Target RESET pin |
| tmr_mode_o | output | 1 | Timer mode bit |
| tmr_lo_o | output | 8 | Timer low reload value |
| tmr_hi_o | output | 8 | Timer high reload value |
| idle_o | output | 1 | Bridge has left byte mode |

## Verification
The bench sends 0x00 as the raw byte after a timer-load code. A bridge that treated that byte as an escape would answer and load nothing. It runs frames under 3-bit width and checks the masking, because a bridge that ignored the width would leak the upper bits into the shift. Random statuses that match and miss `STAT_OK` expose a missing 0xC0 marking or a swapped byte order. In the idle state it sends a byte pair that would otherwise set TMS, so a leaky idle shows up as a pin change or a stray response. The bench also holds off `tx_ready_i` and checks that the held byte does not change, and checks that input stays stalled during a shift.

// File: rtl/jbb_pkg.sv
package jbb_pkg;
  typedef enum logic [2:0] {
    ST_LEN, ST_CMD, ST_DATA, ST_START, ST_SHIFT, ST_TLO, ST_THI, ST_IDLE
  } st_e;

  localparam logic [7:0] C_EXIT   = 8'h00;
  localparam logic [7:0] C_IR     = 8'h01;
  localparam logic [7:0] C_DR     = 8'h02;
  localparam logic [7:0] C_NARROW = 8'h03;
  localparam logic [7:0] C_RST_HI = 8'h04;
  localparam logic [7:0] C_RST_LO = 8'h05;
  localparam logic [7:0] C_TCK    = 8'h06;
  localparam logic [7:0] C_TDO    = 8'h07;
  localparam logic [7:0] C_WIDE   = 8'h08;
  localparam logic [7:0] C_TMS_HI = 8'h09;
  localparam logic [7:0] C_TMS_LO = 8'h0A;
  localparam logic [7:0] C_TDI_HI = 8'h0B;
  localparam logic [7:0] C_TDI_LO = 8'h0C;
  localparam logic [7:0] C_TM_SET = 8'h0D;
  localparam logic [7:0] C_TM_CLR = 8'h0E;
  localparam logic [7:0] C_LD_LO  = 8'h11;
  localparam logic [7:0] C_LD_HI  = 8'h12;

  localparam logic [7:0] E_CMD    = 8'h80;
  localparam logic [7:0] E_STAT   = 8'hC0;

  function automatic logic cmd_known(input logic [7:0] c);
    return (c <= C_TM_CLR) || (c == C_LD_LO) || (c == C_LD_HI);
  endfunction
endpackage

// File: rtl/jbb_resp.sv
module jbb_resp (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic       push_two_i,
  input  logic [7:0] byte0_i,
  input  logic [7:0] byte1_i,
  output logic       empty_o,
  output logic [7:0] tx_data_o,
  output logic       tx_valid_o,
  input  logic       tx_ready_i
);
  logic [7:0] b0_q, b1_q;
  logic [1:0] cnt_q;

  assign empty_o    = (cnt_q == 2'd0);
  assign tx_valid_o = !empty_o;
  assign tx_data_o  = b0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b0_q  <= '0;
      b1_q  <= '0;
      cnt_q <= '0;
    end else if (push_i) begin
      b0_q  <= byte0_i;
      b1_q  <= byte1_i;
      cnt_q <= push_two_i ? 2'd2 : 2'd1;
    end else if (tx_valid_o && tx_ready_i) begin
      b0_q  <= b1_q;
      cnt_q <= cnt_q - 2'd1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> cnt_q == 2'd0); // R3
  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o))); // R11
endmodule

// File: rtl/jbb_pins.sv
module jbb_pins
  import jbb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_stb_i,
  input  logic [7:0] cmd_i,
  input  logic       lo_stb_i,
  input  logic       hi_stb_i,
  input  logic [7:0] raw_i,
  output logic       rst_pin_o,
  output logic       tms_o,
  output logic       tdi_o,
  output logic       tck_o,
  output logic       ir_sel_o,
  output logic       wide_o,
  output logic       tmr_mode_o,
  output logic [7:0] tmr_lo_o,
  output logic [7:0] tmr_hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pin_o  <= 1'b1;
      tms_o      <= 1'b0;
      tdi_o      <= 1'b0;
      tck_o      <= 1'b0;
      ir_sel_o   <= 1'b0;
      wide_o     <= 1'b1;
      tmr_mode_o <= 1'b0;
      tmr_lo_o   <= '0;
      tmr_hi_o   <= '0;
    end else begin
      tck_o <= cmd_stb_i && (cmd_i == C_TCK);
      if (lo_stb_i) tmr_lo_o <= raw_i;
      if (hi_stb_i) tmr_hi_o <= raw_i;
      if (cmd_stb_i) begin
        case (cmd_i)
          C_IR:     ir_sel_o   <= 1'b1;
          C_DR:     ir_sel_o   <= 1'b0;
          C_NARROW: wide_o     <= 1'b0;
          C_WIDE:   wide_o     <= 1'b1;
          C_RST_HI: rst_pin_o  <= 1'b1;
          C_RST_LO: rst_pin_o  <= 1'b0;
          C_TMS_HI: tms_o      <= 1'b1;
          C_TMS_LO: tms_o      <= 1'b0;
          C_TDI_HI: tdi_o      <= 1'b1;
          C_TDI_LO: tdi_o      <= 1'b0;
          C_TM_SET: tmr_mode_o <= 1'b1;
          C_TM_CLR: tmr_mode_o <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  AST_TCK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tck_o |=> !tck_o); // R6
endmodule

// File: rtl/jbb_ctrl.sv
module jbb_ctrl
  import jbb_pkg::*;
#(
  parameter int unsigned STAT_W   = 2,
  parameter int unsigned STAT_OK  = 1,
  parameter int unsigned NARROW_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bin_en_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  input  logic              resp_empty_i,
  output logic              push_o,
  output logic              push_two_o,
  output logic [7:0]        byte0_o,
  output logic [7:0]        byte1_o,
  output logic              cmd_stb_o,
  output logic              lo_stb_o,
  output logic              hi_stb_o,
  input  logic              tdo_i,
  input  logic              wide_i,
  output logic              sh_start_o,
  output logic [7:0]        sh_data_o,
  input  logic              sh_done_i,
  input  logic [7:0]        sh_capt_i,
  input  logic [STAT_W-1:0] sh_status_i,
  output logic              idle_o
);
  localparam logic [7:0] NMASK = 8'((1 << NARROW_W) - 1);
  localparam logic [STAT_W-1:0] OK_CODE = STAT_W'(STAT_OK);

  st_e        st_q, st_d;
  logic [7:0] cnt_q, cnt_d;
  logic [7:0] dat_q;
  logic       acc;

  always_comb begin
    unique case (st_q)
      ST_IDLE:                              rx_ready_o = 1'b1;
      ST_LEN, ST_CMD, ST_DATA, ST_TLO, ST_THI: rx_ready_o = resp_empty_i;
      default:                              rx_ready_o = 1'b0;
    endcase
  end

  assign acc        = rx_valid_i && rx_ready_o;
  assign idle_o     = (st_q == ST_IDLE);
  assign sh_start_o = (st_q == ST_START);
  assign sh_data_o  = dat_q;
  assign cmd_stb_o  = acc && (st_q == ST_CMD);
  assign lo_stb_o   = acc && (st_q == ST_TLO);
  assign hi_stb_o   = acc && (st_q == ST_THI);

  always_comb begin
    push_o     = 1'b0;
    push_two_o = 1'b0;
    byte0_o    = '0;
    byte1_o    = sh_capt_i;
    if (cmd_stb_o) begin
      push_o  = 1'b1;
      if (!cmd_known(rx_data_i))    byte0_o = E_CMD;
      else if (rx_data_i == C_TDO)  byte0_o = {7'd0, tdo_i};
      else                          byte0_o = rx_data_i;
    end else if (st_q == ST_SHIFT && sh_done_i) begin
      push_o     = 1'b1;
      push_two_o = 1'b1;
      byte0_o    = (sh_status_i == OK_CODE) ? 8'(sh_status_i)
                                            : (E_STAT | 8'(sh_status_i));
    end
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_LEN: if (acc) begin
        if (rx_data_i == 8'd0) st_d = ST_CMD;
        else begin
          cnt_d = rx_data_i;
          st_d  = ST_DATA;
        end
      end
      ST_CMD: if (acc) begin
        if      (rx_data_i == C_EXIT)  st_d = ST_IDLE;
        else if (rx_data_i == C_LD_LO) st_d = ST_TLO;
        else if (rx_data_i == C_LD_HI) st_d = ST_THI;
        else                           st_d = ST_LEN;
      end
      ST_DATA:  if (acc) st_d = ST_START;
      ST_START: st_d = ST_SHIFT;
      ST_SHIFT: if (sh_done_i) begin
        cnt_d = cnt_q - 8'd1;
        st_d  = (cnt_q == 8'd1) ? ST_LEN : ST_DATA;
      end
      ST_TLO, ST_THI: if (acc) st_d = ST_LEN;
      ST_IDLE:  if (bin_en_i) st_d = ST_LEN;
      default:  st_d = ST_LEN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_LEN;
      cnt_q <= '0;
      dat_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (acc && st_q == ST_DATA) dat_q <= wide_i ? rx_data_i : (rx_data_i & NMASK);
    end
  end

  AST_DONE_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SHIFT && sh_done_i) |-> resp_empty_i); // R3
  AST_START_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_start_o |=> !rx_ready_o); // R3
  AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !push_o); // R10
endmodule

// File: rtl/jtag_byte_bridge.sv
module jtag_byte_bridge #(
  parameter int unsigned STAT_W   = 2,
  parameter int unsigned STAT_OK  = 1,
  parameter int unsigned NARROW_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bin_en_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic              sh_start_o,
  output logic [7:0]        sh_data_o,
  output logic              sh_ir_o,
  output logic              sh_wide_o,
  input  logic              sh_done_i,
  input  logic [7:0]        sh_capt_i,
  input  logic [STAT_W-1:0] sh_status_i,
  input  logic              tdo_i,
  output logic              tck_o,
  output logic              tms_o,
  output logic              tdi_o,
  output logic              rst_pin_o,
  output logic              tmr_mode_o,
  output logic [7:0]        tmr_lo_o,
  output logic [7:0]        tmr_hi_o,
  output logic              idle_o
);
  logic       resp_empty, push, push_two, cmd_stb, lo_stb, hi_stb;
  logic [7:0] byte0, byte1;

  jbb_ctrl #(.STAT_W(STAT_W), .STAT_OK(STAT_OK), .NARROW_W(NARROW_W)) u_ctrl (
    .clk_i, .rst_ni, .bin_en_i, .rx_data_i, .rx_valid_i, .rx_ready_o,
    .resp_empty_i(resp_empty), .push_o(push), .push_two_o(push_two),
    .byte0_o(byte0), .byte1_o(byte1), .cmd_stb_o(cmd_stb),
    .lo_stb_o(lo_stb), .hi_stb_o(hi_stb), .tdo_i, .wide_i(sh_wide_o),
    .sh_start_o, .sh_data_o, .sh_done_i, .sh_capt_i, .sh_status_i, .idle_o
  );

  jbb_pins u_pins (
    .clk_i, .rst_ni, .cmd_stb_i(cmd_stb), .cmd_i(rx_data_i),
    .lo_stb_i(lo_stb), .hi_stb_i(hi_stb), .raw_i(rx_data_i),
    .rst_pin_o, .tms_o, .tdi_o, .tck_o, .ir_sel_o(sh_ir_o), .wide_o(sh_wide_o),
    .tmr_mode_o, .tmr_lo_o, .tmr_hi_o
  );

  jbb_resp u_resp (
    .clk_i, .rst_ni, .push_i(push), .push_two_i(push_two),
    .byte0_i(byte0), .byte1_i(byte1), .empty_o(resp_empty),
    .tx_data_o, .tx_valid_o, .tx_ready_i
  );
endmodule

// File: tb/sim_jtag_byte_bridge.sv
module sim_jtag_byte_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int STAT_OK = 1;

  logic clk = 0, rst_n = 0;
  logic bin_en = 0, rx_valid = 0, tx_ready = 0, sh_done = 0, tdo = 0;
  logic [7:0] rx_data = 0, sh_capt = 0;
  logic [1:0] sh_status = 0;
  logic rx_ready, tx_valid, sh_start, sh_ir, sh_wide, tck, tms, tdi, rst_pin, tmr_mode, idle;
  logic [7:0] tx_data, sh_data, tmr_lo, tmr_hi;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [1:0] next_stat = 0;
  logic [7:0] seen_data = 0;
  logic seen_ir = 0, seen_wide = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jtag_byte_bridge #(.STAT_W(2), .STAT_OK(STAT_OK), .NARROW_W(3)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bin_en_i(bin_en), .rx_data_i(rx_data),
    .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .tx_data_o(tx_data),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .sh_start_o(sh_start),
    .sh_data_o(sh_data), .sh_ir_o(sh_ir), .sh_wide_o(sh_wide), .sh_done_i(sh_done),
    .sh_capt_i(sh_capt), .sh_status_i(sh_status), .tdo_i(tdo), .tck_o(tck),
    .tms_o(tms), .tdi_o(tdi), .rst_pin_o(rst_pin), .tmr_mode_o(tmr_mode),
    .tmr_lo_o(tmr_lo), .tmr_hi_o(tmr_hi), .idle_o(idle)
  );

  function automatic logic [7:0] capt_of(input logic [7:0] d);
    return d ^ 8'hA5;
  endfunction
  function automatic logic [7:0] stat_byte(input logic [1:0] s);
    return (s == 2'(STAT_OK)) ? {6'd0, s} : (8'hC0 | {6'd0, s});
  endfunction
  function automatic logic [7:0] cmd_resp(input logic [7:0] c, input logic t);
    if (c == 8'h07) return {7'd0, t};
    if (c <= 8'h0E || c == 8'h11 || c == 8'h12) return c;
    return 8'h80;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (!rx_ready) @(negedge clk);
    rx_data = b; rx_valid = 1;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic recv(input string req, input logic [7:0] exp);
    @(negedge clk);
    while (!tx_valid) @(negedge clk);
    chk(req, tx_data, exp);
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
  endtask

  task automatic special(input string req, input logic [7:0] c);
    send(8'h00); send(c);
    recv(req, cmd_resp(c, tdo));
  endtask

  task automatic frame(input int n);
    logic [7:0] d, m;
    send(8'(n));
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      next_stat = 2'($urandom);
      m = sh_wide ? d : (d & 8'h07);
      send(d);
      recv("R3/R4 status", stat_byte(next_stat));
      recv("R3 capture", capt_of(m));
      chk("R2 shifted data", seen_data, m);
    end
  endtask

  // shift engine model
  initial begin
    forever begin
      @(negedge clk);
      if (sh_start) begin
        seen_data = sh_data; seen_ir = sh_ir; seen_wide = sh_wide;
        @(negedge clk);
        chk("R3 stall during shift", {7'd0, rx_ready}, 8'h00);
        sh_done = 1; sh_capt = capt_of(seen_data); sh_status = next_stat;
        @(negedge clk);
        sh_done = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rst pin", {7'd0, rst_pin}, 8'h01);
    chk("R1 pins", {5'd0, tms, tdi, tck}, 8'h00);
    chk("R1 sel", {6'd0, sh_ir, sh_wide}, 8'h01);
    chk("R1 timer", {tmr_lo | tmr_hi, 7'd0} | {7'd0, tmr_mode}, 8'h00);
    chk("R1 flags", {5'd0, idle, tx_valid, rx_ready}, 8'h01);

    // R5 pin codes
    special("R5 tms hi", 8'h09); chk("R5 tms", {7'd0, tms}, 8'h01);
    special("R5 tdi hi", 8'h0B); chk("R5 tdi", {7'd0, tdi}, 8'h01);
    special("R5 rst lo", 8'h05); chk("R5 rst", {7'd0, rst_pin}, 8'h00);
    special("R5 rst hi", 8'h04); chk("R5 rst", {7'd0, rst_pin}, 8'h01);
    special("R5 tms lo", 8'h0A); chk("R5 tms", {7'd0, tms}, 8'h00);
    special("R5 tdi lo", 8'h0C); chk("R5 tdi", {7'd0, tdi}, 8'h00);

    // R6 tck pulse
    send(8'h00); send(8'h06);
    chk("R6 tck high", {7'd0, tck}, 8'h01);
    @(negedge clk);
    chk("R6 tck low", {7'd0, tck}, 8'h00);
    recv("R6 tck echo", 8'h06);
    tdo = 1; special("R6 tdo 1", 8'h07);
    tdo = 0; special("R6 tdo 0", 8'h07);

    // R11 hold while not ready
    send(8'h00); send(8'h0D);
    repeat (4) begin
      @(negedge clk);
      chk("R11 hold", {tx_valid, 7'd0} | (tx_data & 8'h7F), 8'h8D);
    end
    recv("R8 mode echo", 8'h0D);
    chk("R8 mode set", {7'd0, tmr_mode}, 8'h01);
    special("R8 mode clr", 8'h0E); chk("R8 mode", {7'd0, tmr_mode}, 8'h00);

    // R8 raw loads, including a zero raw byte
    send(8'h00); send(8'h11); recv("R8 lo echo", 8'h11); send(8'h3C);
    chk("R8 lo", tmr_lo, 8'h3C);
    send(8'h00); send(8'h12); recv("R8 hi echo", 8'h12); send(8'h00);
    @(negedge clk);
    chk("R8 hi zero", tmr_hi, 8'h00);
    chk("R8 no resp", {7'd0, tx_valid}, 8'h00);
    send(8'h00); send(8'h12); recv("R8 hi echo", 8'h12); send(8'hC3);
    chk("R8 hi", tmr_hi, 8'hC3);

    // R9 unknown codes
    special("R9 0x0F", 8'h0F);
    special("R9 0x10", 8'h10);
    special("R9 0x13", 8'h13);
    special("R9 0xFF", 8'hFF);
    chk("R9 no change", {3'd0, rst_pin, tms, tdi, sh_ir, tmr_mode}, 8'h10);

    // R2/R3/R4 frames, DR wide
    frame(1);
    frame(3);
    chk("R2 dr sel", {7'd0, seen_ir}, 8'h00);
    // R7 IR, narrow
    special("R7 ir", 8'h01); chk("R7 ir", {7'd0, sh_ir}, 8'h01);
    special("R7 narrow", 8'h03); chk("R7 narrow", {7'd0, sh_wide}, 8'h00);
    frame(2);
    chk("R2 ir seen", {6'd0, seen_ir, seen_wide}, 8'h02);
    special("R7 wide", 8'h08); chk("R7 wide", {7'd0, sh_wide}, 8'h01);
    special("R7 dr", 8'h02); chk("R7 dr", {7'd0, sh_ir}, 8'h00);
    for (int k = 0; k < 6; k++) frame(1 + int'($urandom_range(0, 3)));

    // R10 exit and idle
    special("R10 exit echo", 8'h00);
    chk("R10 idle", {7'd0, idle}, 8'h01);
    send(8'h00); send(8'h09);
    repeat (3) @(negedge clk);
    chk("R10 ignored tms", {7'd0, tms}, 8'h00);
    chk("R10 no resp", {7'd0, tx_valid}, 8'h00);
    bin_en = 1; @(negedge clk); bin_en = 0;
    chk("R10 re-enable", {7'd0, idle}, 8'h00);
    special("R10 after", 8'h0B); chk("R10 tdi", {7'd0, tdi}, 8'h01);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule